// File: doc/BRIEF.md
# Parallel-Level Trie Route Lookup

This block resolves the longest matching route for a 32-bit IPv4 destination. It does not walk a binary trie one bit at a time. It probes four fixed prefix lengths (8, 16, 24 and 32 bits) and gives each length its own synchronous RAM, so that the reads for several lengths happen in the same cycle.

A lookup runs in three steps:

1. Read the level-8 and level-16 tables together, indexed straight from the address.
2. Read the two segment tables for lengths 24 and 32. A level-16 entry carries a child-presence flag and a segment pointer for each of these deeper levels. A segment table is read only when its flag is set.
3. Pick the deepest level that hit and register the result.

An optional indirect mode saves next-hop storage. In that mode a segment entry holds a short pointer into a per-level next-hop table, and one extra RAM read is needed.

Lookups enter through a valid/ready handshake and leave through a second valid/ready handshake. Only one lookup is in flight at a time. The tables are loaded through a plain write port. Building and updating the route table are done outside the block.

Top module: `iplkp_trie`

## Requirements
- R1: The level-8 table (write code 0) is indexed by address bits [31:24]. In each entry, bit 15 is the route-present flag and bits [14:0] are the next hop.
- R2: The level-16 table (write code 1) is indexed by address bits [16 +: L16_AW], where L16_AW is 16 for a full-size table. Its entry layout, from the most significant bit down, is: route-present; child-24 flag; child-32 flag; a 24-level segment pointer of S24_W bits; a 32-level segment pointer of S32_W bits; a 15-bit next hop.
- R3: The 24-level segment table (write code 2) is addressed by {24-level pointer, address bits [15:8]}. Its top bit is the route-present flag and the bits below it are the reference. When the child-24 flag is clear, level 24 counts as a miss.
- R4: The 32-level segment table (write code 3) is addressed by {32-level pointer, address bits [7:0]}. It uses the same layout as the 24-level table. When the child-32 flag is clear, level 32 counts as a miss.
- R5: When several levels hit, level 32 has the highest priority, then 24, then 16, then 8.
- R6: When no level hits, out_hit is 0 and out_nh is 0.
- R7: With NH_INDIRECT=0, the segment reference is the 15-bit next hop itself. With NH_INDIRECT=1, the reference is a PTR_W-bit index into a per-level next-hop table: write code 4 for level 24, write code 5 for level 32.
- R8: out_valid rises exactly 3 clock edges after the accepting edge when NH_INDIRECT=0, and 4 edges after it when NH_INDIRECT=1.
- R9: in_ready is high only when no lookup is in flight. It goes low on the accepting edge and stays low until the result is consumed.
- R10: While out_valid is high and out_ready is low, out_valid, out_hit and out_nh hold their values. The edge on which out_ready is high consumes the result.
- R11: After reset, in_ready is 1 and out_valid, out_hit and out_nh are 0.
- R12: A write with wr_en high stores wr_data at wr_addr in the table chosen by wr_tbl. Later lookups return the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Lookup request present |
| in_ready | output | 1 | Block can accept a lookup |
| in_addr | input | 32 | Destination address |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_hit | output | 1 | At least one level matched |
| out_nh | output | NH_W | Next hop of the longest match, zero on a miss |
| wr_en | input | 1 | Table write strobe |
| wr_tbl | input | 3 | Table select code (0 to 5) |
| wr_addr | input | WA_W | Entry index within the chosen table |
| wr_data | input | WD_W | Entry contents, right-aligned |

## Verification
The assertions take three things for granted about the inputs:
- in_valid stays low while reset is asserted, so the latency check never looks back at a request made during reset.
- Tables are not written while a lookup is in flight.
- In indirect mode, each pointer selects an entry that has been loaded.

The bench respects all three. It loads every entry of every table of both instances before the first request, it writes only between lookups, and it keeps its request low until reset has been released.

The sweep covers every level-16 entry of a small configuration against several level-8 and segment byte values. This exercises each child-flag combination and each overlap of hits.

// File: rtl/lk_pkg.sv
package lk_pkg;

  typedef enum logic [2:0] {
    LK_IDLE = 3'd0,
    LK_P1   = 3'd1,
    LK_P2   = 3'd2,
    LK_P3   = 3'd3,
    LK_DONE = 3'd4
  } lk_state_e;

  localparam logic [2:0] LK_T8   = 3'd0;
  localparam logic [2:0] LK_T16  = 3'd1;
  localparam logic [2:0] LK_T24  = 3'd2;
  localparam logic [2:0] LK_T32  = 3'd3;
  localparam logic [2:0] LK_NH24 = 3'd4;
  localparam logic [2:0] LK_NH32 = 3'd5;

  function automatic int lk_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lk_ram.sv
module lk_ram #(
  parameter int DW = 8,
  parameter int AW = 4,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);

  logic [DW-1:0] mem [DEPTH];

  // one write port, one registered read port; output holds while re is low
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) rd <= mem[ra];
  end

endmodule

// File: rtl/lk_prio_sel.sv
module lk_prio_sel #(
  parameter int LEVELS = 4,
  parameter int NH_W   = 15
) (
  input  logic [LEVELS-1:0]           lv_hit,
  input  logic [LEVELS-1:0][NH_W-1:0] lv_nh,
  output logic                        hit,
  output logic [NH_W-1:0]             nh
);

  // index 0 is the shortest prefix; later (longer) levels override
  always_comb begin
    hit = 1'b0;
    nh  = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (lv_hit[i]) begin
        hit = 1'b1;
        nh  = lv_nh[i];
      end
    end
  end

endmodule

// File: rtl/iplkp_trie.sv
module iplkp_trie
  import lk_pkg::*;
#(
  parameter int NH_W        = 15,
  parameter int L16_AW      = 10,
  parameter int S24_W       = 3,
  parameter int S32_W       = 2,
  parameter int NH_INDIRECT = 0,
  parameter int PTR_W       = 8,
  localparam int E8_W   = NH_W + 1,
  localparam int E16_W  = NH_W + 3 + S24_W + S32_W,
  localparam int REF_W  = (NH_INDIRECT != 0) ? PTR_W : NH_W,
  localparam int ESEG_W = REF_W + 1,
  localparam int A24_W  = S24_W + 8,
  localparam int A32_W  = S32_W + 8,
  localparam int WD_W   = E16_W,
  localparam int WA_W   = lk_max(lk_max(lk_max(8, L16_AW), lk_max(A24_W, A32_W)), PTR_W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     in_addr,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_hit,
  output logic [NH_W-1:0] out_nh,
  input  logic            wr_en,
  input  logic [2:0]      wr_tbl,
  input  logic [WA_W-1:0] wr_addr,
  input  logic [WD_W-1:0] wr_data
);

  localparam int LAT = (NH_INDIRECT != 0) ? 4 : 3;

  // ---------------- reset: asserted asynchronously, released on clk
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  // ---------------- control
  lk_state_e state_q, state_d;
  logic      accept;
  logic      load_res;
  logic [15:0] addr_lo_q;

  assign in_ready  = (state_q == LK_IDLE);
  assign out_valid = (state_q == LK_DONE);
  assign accept    = in_valid && in_ready;
  assign load_res  = ((state_q == LK_P2) && (NH_INDIRECT == 0)) || (state_q == LK_P3);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LK_IDLE: if (accept) state_d = LK_P1;
      LK_P1:   state_d = LK_P2;
      LK_P2:   state_d = (NH_INDIRECT != 0) ? LK_P3 : LK_DONE;
      LK_P3:   state_d = LK_DONE;
      LK_DONE: if (out_ready) state_d = LK_IDLE;
      default: state_d = LK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) state_q <= LK_IDLE;
    else          state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)    addr_lo_q <= '0;
    else if (accept) addr_lo_q <= in_addr[15:0];
  end

  // ---------------- phase 1: global level-8 and level-16 tables
  logic [E8_W-1:0]  r8;
  logic [E16_W-1:0] r16;

  lk_ram #(.DW(E8_W), .AW(8)) u_t8 (
    .clk(clk), .we(wr_en && (wr_tbl == LK_T8)), .wa(wr_addr[7:0]),
    .wd(wr_data[E8_W-1:0]), .re(accept), .ra(in_addr[31:24]), .rd(r8)
  );

  lk_ram #(.DW(E16_W), .AW(L16_AW)) u_t16 (
    .clk(clk), .we(wr_en && (wr_tbl == LK_T16)), .wa(wr_addr[L16_AW-1:0]),
    .wd(wr_data[E16_W-1:0]), .re(accept), .ra(in_addr[16 +: L16_AW]), .rd(r16)
  );

  logic             p16, c24, c32;
  logic [S24_W-1:0] seg24;
  logic [S32_W-1:0] seg32;

  assign p16   = r16[E16_W-1];
  assign c24   = r16[E16_W-2];
  assign c32   = r16[E16_W-3];
  assign seg24 = r16[NH_W+S32_W +: S24_W];
  assign seg32 = r16[NH_W +: S32_W];

  // ---------------- phase 2: partial segments, read only when a child exists
  logic [ESEG_W-1:0] r24, r32;

  lk_ram #(.DW(ESEG_W), .AW(A24_W)) u_t24 (
    .clk(clk), .we(wr_en && (wr_tbl == LK_T24)), .wa(wr_addr[A24_W-1:0]),
    .wd(wr_data[ESEG_W-1:0]), .re((state_q == LK_P1) && c24),
    .ra({seg24, addr_lo_q[15:8]}), .rd(r24)
  );

  lk_ram #(.DW(ESEG_W), .AW(A32_W)) u_t32 (
    .clk(clk), .we(wr_en && (wr_tbl == LK_T32)), .wa(wr_addr[A32_W-1:0]),
    .wd(wr_data[ESEG_W-1:0]), .re((state_q == LK_P1) && c32),
    .ra({seg32, addr_lo_q[7:0]}), .rd(r32)
  );

  // ---------------- phase 3 (indirect only): per-level next-hop tables
  logic [NH_W-1:0] cand24, cand32;

  generate
    if (NH_INDIRECT != 0) begin : g_ind
      lk_ram #(.DW(NH_W), .AW(PTR_W)) u_nh24 (
        .clk(clk), .we(wr_en && (wr_tbl == LK_NH24)), .wa(wr_addr[PTR_W-1:0]),
        .wd(wr_data[NH_W-1:0]), .re(state_q == LK_P2),
        .ra(r24[REF_W-1:0]), .rd(cand24)
      );
      lk_ram #(.DW(NH_W), .AW(PTR_W)) u_nh32 (
        .clk(clk), .we(wr_en && (wr_tbl == LK_NH32)), .wa(wr_addr[PTR_W-1:0]),
        .wd(wr_data[NH_W-1:0]), .re(state_q == LK_P2),
        .ra(r32[REF_W-1:0]), .rd(cand32)
      );
    end else begin : g_dir
      assign cand24 = r24[NH_W-1:0];
      assign cand32 = r32[NH_W-1:0];
    end
  endgenerate

  // ---------------- longest-match selection and result register
  logic            sel_hit;
  logic [NH_W-1:0] sel_nh;

  lk_prio_sel #(.LEVELS(4), .NH_W(NH_W)) u_sel (
    .lv_hit({c32 && r32[REF_W], c24 && r24[REF_W], p16, r8[NH_W]}),
    .lv_nh ({cand32, cand24, r16[NH_W-1:0], r8[NH_W-1:0]}),
    .hit   (sel_hit),
    .nh    (sel_nh)
  );

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      out_hit <= 1'b0;
      out_nh  <= '0;
    end else if (load_res) begin
      out_hit <= sel_hit;
      out_nh  <= sel_nh;
    end
  end

  // ---------------- assertions
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_s_n)
    accept |=> !in_ready);

  a_r9_single_outstanding: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_valid |-> !in_ready);

  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hit) && $stable(out_nh)));

  a_r6_miss_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && !out_hit) |-> (out_nh == '0));

  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(out_valid) |-> $past(accept, LAT));

  a_r8_no_late: assert property (@(posedge clk) disable iff (!rst_s_n)
    $past(accept, LAT) |-> out_valid);

endmodule

// File: tb/iplkp_trie_bench.sv
module iplkp_trie_bench;

  localparam int CLK_PERIOD = 10;
  localparam int L16 = 4, S24 = 2, S32 = 1, PW = 6;
  localparam int WD = 21, WA = 10;

  logic clk, rst_n;
  logic in_valid, out_ready;
  logic [31:0] in_addr;
  logic rdy_d, rdy_i, vld_d, vld_i, hit_d, hit_i;
  logic [14:0] nh_d, nh_i;
  logic d_we, i_we;
  logic [2:0] wtbl;
  logic [WA-1:0] waddr;
  logic [WD-1:0] d_wd, i_wd;

  int n_cmp, n_bad;
  int ov_top;
  bit done;

  iplkp_trie #(.L16_AW(L16), .S24_W(S24), .S32_W(S32), .NH_INDIRECT(0), .PTR_W(PW)) u_iplkp_trie (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_d), .in_addr(in_addr),
    .out_valid(vld_d), .out_ready(out_ready), .out_hit(hit_d), .out_nh(nh_d),
    .wr_en(d_we), .wr_tbl(wtbl), .wr_addr(waddr), .wr_data(d_wd));

  iplkp_trie #(.L16_AW(L16), .S24_W(S24), .S32_W(S32), .NH_INDIRECT(1), .PTR_W(PW)) u_iplkp_trie_ind (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_i), .in_addr(in_addr),
    .out_valid(vld_i), .out_ready(out_ready), .out_hit(hit_i), .out_nh(nh_i),
    .wr_en(i_we), .wr_tbl(wtbl), .wr_addr(waddr), .wr_data(i_wd));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---- table contents, computed
  function automatic bit p8f(input int t);
    return (t == ov_top) ? 1'b1 : ((t % 3) == 0);
  endfunction
  function automatic int nh8f(input int t);
    return (t == ov_top) ? 'h7777 : 256 + t;
  endfunction

  task automatic wr(input logic [2:0] tbl, input int a, input logic [WD-1:0] dd,
                    input logic [WD-1:0] di, input bit den, input bit ien);
    @(negedge clk);
    wtbl = tbl; waddr = WA'(a); d_wd = dd; i_wd = di; d_we = den; i_we = ien;
    @(negedge clk);
    d_we = 1'b0; i_we = 1'b0;
  endtask

  task automatic load_all();
    logic [WD-1:0] v, vi;
    for (int a = 0; a < 256; a++) begin
      v = {5'b0, p8f(a), 15'(nh8f(a))};
      wr(3'd0, a, v, v, 1'b1, 1'b1);
    end
    for (int j = 0; j < 16; j++) begin
      v = {1'(j % 2), 1'((j % 5) != 0), 1'((j / 2) % 2), 2'(j % 4), 1'(j % 2), 15'(512 + j)};
      wr(3'd1, j, v, v, 1'b1, 1'b1);
    end
    for (int s = 0; s < 4; s++)
      for (int b = 0; b < 256; b++) begin
        v  = {5'b0, 1'(((b + s) % 4) == 0), 15'(4096 + s * 256 + b)};
        vi = {14'b0, 1'(((b + s) % 4) == 0), 6'((s * 8 + b) % 64)};
        wr(3'd2, s * 256 + b, v, vi, 1'b1, 1'b1);
      end
    for (int s = 0; s < 2; s++)
      for (int b = 0; b < 256; b++) begin
        v  = {5'b0, 1'(((b + s) % 5) == 0), 15'(8192 + s * 256 + b)};
        vi = {14'b0, 1'(((b + s) % 5) == 0), 6'((s * 16 + b) % 64)};
        wr(3'd3, s * 256 + b, v, vi, 1'b1, 1'b1);
      end
    for (int p = 0; p < 64; p++) begin
      wr(3'd4, p, '0, {6'b0, 15'(12288 + p)}, 1'b0, 1'b1);
      wr(3'd5, p, '0, {6'b0, 15'(16384 + p)}, 1'b0, 1'b1);
    end
  endtask

  task automatic lookup(input int top, input int j, input int b2, input int b1);
    bit p8, p16, c24, c32, p24, p32, eh;
    int s24, s32, ed, ei, nm;
    string tag;
    p8  = p8f(top);
    p16 = (j % 2) == 1;
    c24 = (j % 5) != 0;
    c32 = ((j / 2) % 2) == 1;
    s24 = j % 4;
    s32 = j % 2;
    p24 = c24 && (((b2 + s24) % 4) == 0);
    p32 = c32 && (((b1 + s32) % 5) == 0);
    eh  = p8 | p16 | p24 | p32;
    nm  = int'(p8) + int'(p16) + int'(p24) + int'(p32);
    ed = 0; ei = 0;
    if (p8)  begin ed = nh8f(top); ei = ed; end
    if (p16) begin ed = 512 + j;   ei = ed; end
    if (p24) begin ed = 4096 + s24 * 256 + b2; ei = 12288 + (s24 * 8 + b2) % 64; end
    if (p32) begin ed = 8192 + s32 * 256 + b1; ei = 16384 + (s32 * 16 + b1) % 64; end
    if (top == ov_top)  tag = "R12";
    else if (p32)       tag = "R4";
    else if (p24)       tag = "R3";
    else if (p16)       tag = "R2";
    else if (p8)        tag = "R1";
    else                tag = "R6";
    if (nm > 1) tag = {tag, "/R5"};

    @(negedge clk);
    in_valid = 1'b1;
    in_addr  = {8'(top), 4'h0, 4'(j), 8'(b2), 8'(b1)};
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 busy d", 32'(rdy_d), 0);
    chk("R9 busy i", 32'(rdy_i), 0);
    chk("R8 early d", 32'(vld_d), 0);
    @(negedge clk);
    chk("R8 early d2", 32'(vld_d), 0);
    @(negedge clk);
    chk("R8 valid d", 32'(vld_d), 1);
    chk("R8 early i", 32'(vld_i), 0);
    chk({tag, " hit d"}, 32'(hit_d), 32'(eh));
    chk({tag, " nh d"}, 32'(nh_d), 32'(ed));
    @(negedge clk);
    chk("R8 valid i", 32'(vld_i), 1);
    chk({"R7 ", tag, " hit i"}, 32'(hit_i), 32'(eh));
    chk({"R7 ", tag, " nh i"}, 32'(nh_i), 32'(ei));
    chk("R10 hold valid d", 32'(vld_d), 1);
    chk("R10 hold nh d", 32'(nh_d), 32'(ed));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R10 consumed d", 32'(vld_d), 0);
    chk("R10 consumed i", 32'(vld_i), 0);
    chk("R9 ready again", 32'({rdy_d, rdy_i}), 3);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    int tops[3];
    int b2s[6];
    int b1s[4];
    tops = '{0, 3, 5};
    b2s  = '{0, 1, 2, 3, 4, 8};
    b1s  = '{0, 1, 5, 10};
    n_cmp = 0; n_bad = 0; done = 1'b0; ov_top = -1;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_addr = '0;
    d_we = 1'b0; i_we = 1'b0; wtbl = '0; waddr = '0; d_wd = '0; i_wd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 in_ready d", 32'(rdy_d), 1);
    chk("R11 in_ready i", 32'(rdy_i), 1);
    chk("R11 out_valid", 32'({vld_d, vld_i}), 0);
    chk("R11 out_hit", 32'({hit_d, hit_i}), 0);
    chk("R11 out_nh d", 32'(nh_d), 0);
    chk("R11 out_nh i", 32'(nh_i), 0);
    load_all();
    foreach (tops[t])
      for (int j = 0; j < 16; j++)
        foreach (b2s[x])
          foreach (b1s[y])
            lookup(tops[t], j, b2s[x], b1s[y]);
    // R12: rewrite a level-8 entry and observe the new route
    ov_top = 5;
    wr(3'd0, 5, {5'b0, 1'b1, 15'h7777}, {5'b0, 1'b1, 15'h7777}, 1'b1, 1'b1);
    lookup(5, 0, 1, 1);
    lookup(5, 4, 2, 3);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule